// File: doc/BRIEF.md
# Tape EAR Waveform Player

The block turns a stream of nine-bit entries from a show-ahead FIFO into the square wave that a cassette deck would present on a home computer's EAR input. Bit 8 of each entry tells a command opcode apart from a data byte. Commands program the pulse lengths, the block length and a repeat count, and they also play single pulses or silent gaps. Data bytes are played out as bit pulses. All durations are counted in emulated CPU T-states, and one T-state arrives as a one-cycle strobe on `tstate_tick`.

A driver writes a short prologue of commands into the FIFO. A typical prologue holds the widths for a zero bit and a one bit, a repeat count followed by a pilot pulse, two sync pulses and the block length. The block's data bytes come after it. Every command argument is one 16-bit value, sent low byte first, in the two FIFO entries that follow the opcode. Every pulse ends with an inversion of the EAR level, and a bit is sent as two equal pulses.

Top module: `tape_pulse_player`

## Requirements
- R1: An entry is read (`fifo_rd` high for one cycle, entry consumed at that edge) only while `fifo_empty` is low and `busy` is low. Bit 8 set marks a command with its opcode in bits 7:0; bit 8 clear marks a data byte. The two entries after an opcode 0x80 to 0x86 are its argument, low byte first, whatever their bit 8.
- R2: Opcode 0x80 sets the zero-bit width and 0x81 sets the one-bit width. A new width applies from the next data byte on, including within a block whose bytes are still pending.
- R3: A data byte whose block count is nonzero plays its bits MSB first. Each bit is two pulses of the width selected by the bit value. Each pulse ends when its width in counted ticks has elapsed, and at that point EAR inverts.
- R4: Opcode 0x83 writes count bits 15:0. Opcode 0x84 writes count bits 23:16 from argument bits 7:0 and the unused-bit number U from argument bits 10:8. The byte played when the count is 1 sends only its top 8−U bits.
- R5: A data byte that arrives while the count is zero, and a command byte outside 0x80 to 0x87, are discarded with no effect on EAR or on any setting.
- R6: Opcode 0x86 plays one pulse whose width is its argument.
- R7: Opcode 0x85 stores a repeat count N. The next command consumes it: a pulse or gap then plays N times, or once when N is 0, and any other command clears it without effect.
- R8: Opcode 0x82 drives EAR low at once and holds it low for the argument's number of ticks, with no inversion at the end.
- R9: Opcode 0x87 sets the block count and the pending repeat count to zero, so the following data bytes are discarded.
- R10: A width or gap argument of 0 is timed as 1 tick.
- R11: `busy` is high exactly while a pulse, bit or gap is being timed. Only ticks seen with `busy` high are counted. While `busy` is high, EAR changes only in a cycle that carries a tick.
- R12: After reset, EAR and `busy` are low, the widths hold the parameters `DEF_ZERO_W` and `DEF_ONE_W`, and the count and repeat are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_data | input | 9 | Head entry: bit 8 command flag, bits 7:0 payload |
| fifo_rd | output | 1 | Pop the head entry |
| tstate_tick | input | 1 | One emulated T-state elapsed |
| ear | output | 1 | Tape EAR level |
| busy | output | 1 | A pulse, bit or gap is being timed |

## Verification
Two events can fall in the same cycle. The tick that ends one pulse can also be the cycle in which the next pulse of a repeat, or the second half of a bit, is loaded. The start of a gap can also meet an EAR that is already low. The bench drives ticks at random density, including back-to-back strobes, through long repeated pulses, bit streams and gaps that follow a high EAR. It time-stamps every EAR edge in ticks counted only while `busy` is high. Each stamp and level is compared with an event list that a bench model builds from the same command program.

// File: rtl/tape_pulse_pkg.sv
// Shared definitions for the tape EAR player: argument and count widths,
// opcode values and controller states. Assumes 16-bit command arguments.
package tape_pulse_pkg;
    localparam int ARG_W = 16;
    localparam int LEN_W = 24;
    localparam int ENTRY_W = 9;

    typedef enum logic [7:0] {
        OP_ZERO_W = 8'h80,
        OP_ONE_W  = 8'h81,
        OP_GAP    = 8'h82,
        OP_LEN_LO = 8'h83,
        OP_LEN_HI = 8'h84,
        OP_REPEAT = 8'h85,
        OP_PULSE  = 8'h86,
        OP_FLUSH  = 8'h87
    } tp_op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_ARG,
        ST_EXEC,
        ST_PULSE,
        ST_GAP,
        ST_BIT_A,
        ST_BIT_B
    } tp_state_e;
endpackage

// File: rtl/tpp_tick_timer.sv
// Down-counter of T-state ticks. A load sets the duration (0 counts as 1);
// while run is high each tick decrements, and expire flags the tick that
// completes the duration. Assumes the owner reloads or stops on expire.
module tpp_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt == ONE);

    // Purpose: hold the remaining tick count of the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ONE;
        end else if (load) begin
            cnt <= (load_val == '0) ? ONE : load_val;
        end else if (run && tick && (cnt > ONE)) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/tpp_bit_shifter.sv
// Holds the byte being played and the number of bits still to send.
// cur_bit is the bit in flight, next_bit the one after it. Assumes
// load_bits is between 1 and 8.
module tpp_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [BYTE_W-1:0]         load_byte,
    input  logic [$clog2(BYTE_W+1)-1:0] load_bits,
    input  logic                      advance,
    output logic                      cur_bit,
    output logic                      next_bit,
    output logic                      last_bit
);
    localparam int BC_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh;
    logic [BC_W-1:0]   left;

    assign cur_bit  = sh[BYTE_W-1];
    assign next_bit = sh[BYTE_W-2];
    assign last_bit = (left == BC_W'(1));

    // Purpose: load a new byte or step to the next bit, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= load_byte;
            left <= load_bits;
        end else if (advance) begin
            sh   <= {sh[BYTE_W-2:0], 1'b0};
            left <= left - BC_W'(1);
        end
    end
endmodule

// File: rtl/tpp_ctrl.sv
// Command decoder and playback sequencer. Reads entries from a show-ahead
// FIFO, gathers 16-bit little-endian arguments, keeps widths, block count,
// unused-bit number and repeat count, and drives the EAR level. The tick
// timer and bit shifter are outside; this module tells them when to load.
module tpp_ctrl
    import tape_pulse_pkg::*;
#(
    parameter int DEF_ZERO_W = 855,
    parameter int DEF_ONE_W  = 1710
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_empty,
    input  logic [ENTRY_W-1:0] fifo_data,
    output logic               fifo_rd,
    input  logic               expire,
    output logic               tmr_load,
    output logic [ARG_W-1:0]   tmr_val,
    output logic               sh_load,
    output logic [7:0]         sh_byte,
    output logic [3:0]         sh_bits,
    output logic               sh_adv,
    input  logic               cur_bit,
    input  logic               next_bit,
    input  logic               last_bit,
    output logic               ear,
    output logic               busy,
    output logic               gap_active
);
    tp_state_e        state;
    tp_op_e           opc;
    logic [ARG_W-1:0] arg;
    logic             arg_idx;
    logic [ARG_W-1:0] zero_w;
    logic [ARG_W-1:0] one_w;
    logic [LEN_W-1:0] len;
    logic [2:0]       unused;
    logic [ARG_W-1:0] rep;
    logic [ARG_W-1:0] plays;

    logic       is_cmd;
    logic [7:0] pay;
    logic       op_known;
    logic       data_play;
    logic       exec_play;
    logic       rep_more;

    assign is_cmd     = fifo_data[ENTRY_W-1];
    assign pay        = fifo_data[7:0];
    assign op_known   = (pay[7:3] == 5'b10000);
    assign busy       = (state == ST_PULSE) || (state == ST_GAP) ||
                        (state == ST_BIT_A) || (state == ST_BIT_B);
    assign gap_active = (state == ST_GAP);
    assign fifo_rd    = rst_n && !fifo_empty &&
                        ((state == ST_FETCH) || (state == ST_ARG));
    assign data_play  = (state == ST_FETCH) && !fifo_empty && !is_cmd &&
                        (len != '0);
    assign exec_play  = (state == ST_EXEC) &&
                        ((opc == OP_PULSE) || (opc == OP_GAP));
    assign rep_more   = (plays > ARG_W'(1));

    // Purpose: start the shifter on a byte, cutting the final byte short.
    always_comb begin
        sh_load = data_play;
        sh_byte = pay;
        sh_bits = (len == LEN_W'(1)) ? (4'd8 - {1'b0, unused}) : 4'd8;
        sh_adv  = (state == ST_BIT_B) && expire && !last_bit;
    end

    // Purpose: choose when the tick timer reloads and with which width.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = arg;
        if (data_play) begin
            tmr_load = 1'b1;
            tmr_val  = pay[7] ? one_w : zero_w;
        end else if (exec_play) begin
            tmr_load = 1'b1;
            tmr_val  = arg;
        end else if (((state == ST_PULSE) || (state == ST_GAP)) &&
                     expire && rep_more) begin
            tmr_load = 1'b1;
            tmr_val  = arg;
        end else if ((state == ST_BIT_A) && expire) begin
            tmr_load = 1'b1;
            tmr_val  = cur_bit ? one_w : zero_w;
        end else if ((state == ST_BIT_B) && expire && !last_bit) begin
            tmr_load = 1'b1;
            tmr_val  = next_bit ? one_w : zero_w;
        end
    end

    // Purpose: sequence fetch, argument capture, execution and playback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            opc     <= OP_FLUSH;
            arg     <= '0;
            arg_idx <= 1'b0;
            zero_w  <= ARG_W'(DEF_ZERO_W);
            one_w   <= ARG_W'(DEF_ONE_W);
            len     <= '0;
            unused  <= '0;
            rep     <= '0;
            plays   <= '0;
            ear     <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: begin
                    if (!fifo_empty) begin
                        if (is_cmd) begin
                            if (op_known && (tp_op_e'(pay) == OP_FLUSH)) begin
                                len <= '0;
                                rep <= '0;
                            end else if (op_known) begin
                                opc     <= tp_op_e'(pay);
                                arg_idx <= 1'b0;
                                state   <= ST_ARG;
                            end
                        end else if (data_play) begin
                            len   <= len - LEN_W'(1);
                            state <= ST_BIT_A;
                        end
                    end
                end
                ST_ARG: begin
                    if (!fifo_empty) begin
                        if (!arg_idx) begin
                            arg[7:0] <= pay;
                            arg_idx  <= 1'b1;
                        end else begin
                            arg[15:8] <= pay;
                            state     <= ST_EXEC;
                        end
                    end
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    rep   <= '0;
                    case (opc)
                        OP_ZERO_W: zero_w <= arg;
                        OP_ONE_W:  one_w  <= arg;
                        OP_LEN_LO: len[15:0] <= arg;
                        OP_LEN_HI: begin
                            len[23:16] <= arg[7:0];
                            unused     <= arg[10:8];
                        end
                        OP_REPEAT: rep <= arg;
                        OP_PULSE: begin
                            plays <= (rep == '0) ? ARG_W'(1) : rep;
                            state <= ST_PULSE;
                        end
                        OP_GAP: begin
                            plays <= (rep == '0) ? ARG_W'(1) : rep;
                            ear   <= 1'b0;
                            state <= ST_GAP;
                        end
                        default: ;
                    endcase
                end
                ST_PULSE: begin
                    if (expire) begin
                        ear <= ~ear;
                        if (rep_more) plays <= plays - ARG_W'(1);
                        else          state <= ST_FETCH;
                    end
                end
                ST_GAP: begin
                    if (expire) begin
                        if (rep_more) plays <= plays - ARG_W'(1);
                        else          state <= ST_FETCH;
                    end
                end
                ST_BIT_A: begin
                    if (expire) begin
                        ear   <= ~ear;
                        state <= ST_BIT_B;
                    end
                end
                ST_BIT_B: begin
                    if (expire) begin
                        ear   <= ~ear;
                        state <= last_bit ? ST_FETCH : ST_BIT_A;
                    end
                end
                default: state <= ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/tape_pulse_player.sv
// Top of the tape EAR player: joins the sequencer, the T-state timer and
// the bit shifter. Assumes a show-ahead FIFO (head entry valid while not
// empty) and a tick strobe one clock wide per emulated T-state.
module tape_pulse_player
    import tape_pulse_pkg::*;
#(
    parameter int DEF_ZERO_W = 855,
    parameter int DEF_ONE_W  = 1710
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_empty,
    input  logic [8:0]   fifo_data,
    output logic         fifo_rd,
    input  logic         tstate_tick,
    output logic         ear,
    output logic         busy
);
    logic             expire;
    logic             tmr_load;
    logic [ARG_W-1:0] tmr_val;
    logic             sh_load;
    logic [7:0]       sh_byte;
    logic [3:0]       sh_bits;
    logic             sh_adv;
    logic             cur_bit;
    logic             next_bit;
    logic             last_bit;
    logic             gap_active;

    tpp_ctrl #(
        .DEF_ZERO_W(DEF_ZERO_W),
        .DEF_ONE_W (DEF_ONE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_empty(fifo_empty),
        .fifo_data (fifo_data),
        .fifo_rd   (fifo_rd),
        .expire    (expire),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .sh_load   (sh_load),
        .sh_byte   (sh_byte),
        .sh_bits   (sh_bits),
        .sh_adv    (sh_adv),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit),
        .last_bit  (last_bit),
        .ear       (ear),
        .busy      (busy),
        .gap_active(gap_active)
    );

    tpp_tick_timer #(.CNT_W(ARG_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .run     (busy),
        .tick    (tstate_tick),
        .expire  (expire)
    );

    tpp_bit_shifter #(.BYTE_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_byte(sh_byte),
        .load_bits(sh_bits),
        .advance  (sh_adv),
        .cur_bit  (cur_bit),
        .next_bit (next_bit),
        .last_bit (last_bit)
    );
endmodule

// File: rtl/tpp_checker.sv
// Protocol and timing properties of the tape EAR player, bound to the top.
module tpp_checker (
    input logic clk,
    input logic rst_n,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic tick,
    input logic ear,
    input logic busy,
    input logic gap_active
);
    // R1: never pop an empty FIFO
    p_rd_not_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R11: no read while an interval is being timed
    p_no_rd_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fifo_rd);

    // R11: EAR only moves on a counted tick while timing
    p_ear_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(ear));

    // R8: EAR is low for the whole gap
    p_gap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |-> !ear);

    // R12: reset leaves EAR and busy low
    p_reset_idle_r12: assert property (@(posedge clk)
        !rst_n |=> (!ear && !busy));
endmodule

bind tape_pulse_player tpp_checker u_tpp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .tick      (tstate_tick),
    .ear       (ear),
    .busy      (busy),
    .gap_active(gap_active)
);

// File: tb/tb_tape_pulse_player.sv
`timescale 1ns/1ps
module tb_tape_pulse_player;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic [8:0] fmem [0:2047];
    int         wp = 0;
    int         rp = 0;
    logic       fifo_empty;
    logic [8:0] fifo_data;
    logic       fifo_rd;
    logic       tick;
    logic       ear;
    logic       busy;

    assign fifo_empty = (rp == wp);
    assign fifo_data  = fmem[rp];

    tape_pulse_player #(.DEF_ZERO_W(3), .DEF_ONE_W(6)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .tstate_tick(tick),
        .ear        (ear),
        .busy       (busy)
    );

    // FIFO pop
    always @(posedge clk) if (rst_n && fifo_rd && !fifo_empty) rp <= rp + 1;

    int nchecks = 0;
    int nfail   = 0;
    bit done    = 0;
    bit run_ticks = 0;

    // bench model state
    int    m_zero = 3, m_one = 6, m_rep = 0, m_len = 0, m_unused = 0, m_t = 0;
    bit    m_e = 0;
    int    exp_t [0:8191];
    bit    exp_l [0:8191];
    string exp_r [0:8191];
    int    n_exp = 0;
    int    idx = 0;

    task automatic chk(bit ok, string r, int act, int expv);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
        end
    endtask

    function automatic int eff(int w);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic rec(string r);
        exp_t[n_exp] = m_t; exp_l[n_exp] = m_e; exp_r[n_exp] = r; n_exp++;
    endtask

    task automatic put(logic [8:0] v);
        fmem[wp] = v; wp++;
    endtask

    task automatic put_cmd(logic [7:0] op, int a);
        put({1'b1, op}); put({1'b0, 8'(a)}); put({1'b0, 8'(a >> 8)});
    endtask

    task automatic m_pulse(int w, string r);
        m_t += eff(w); m_e = ~m_e; rec(r);
    endtask

    task automatic c_zero(int w); put_cmd(8'h80, w); m_zero = w; m_rep = 0; endtask
    task automatic c_one(int w);  put_cmd(8'h81, w); m_one = w;  m_rep = 0; endtask
    task automatic c_len_lo(int v);
        put_cmd(8'h83, v); m_len = (m_len & 32'hFF0000) | (v & 32'hFFFF); m_rep = 0;
    endtask
    task automatic c_len_hi(int a);
        put_cmd(8'h84, a); m_len = (m_len & 32'hFFFF) | ((a & 255) << 16);
        m_unused = (a >> 8) & 7; m_rep = 0;
    endtask
    task automatic c_rep(int n); put_cmd(8'h85, n); m_rep = n; endtask
    task automatic c_pulse(int w, string r);
        int plays;
        put_cmd(8'h86, w);
        plays = (m_rep == 0) ? 1 : m_rep;
        for (int i = 0; i < plays; i++) m_pulse(w, r);
        m_rep = 0;
    endtask
    task automatic c_gap(int w, string r);
        int plays;
        put_cmd(8'h82, w);
        plays = (m_rep == 0) ? 1 : m_rep;
        if (m_e) begin m_e = 0; rec(r); end
        m_t += plays * eff(w);
        m_rep = 0;
    endtask
    task automatic c_flush(); put({1'b1, 8'h87}); m_len = 0; m_rep = 0; endtask
    task automatic d_byte(logic [7:0] b, string r);
        int nb;
        string rr;
        put({1'b0, b});
        if (m_len == 0) return;
        nb = (m_len == 1) ? 8 - m_unused : 8;
        rr = (nb < 8) ? "R4" : r;
        m_len--;
        for (int i = 0; i < nb; i++) begin
            int w;
            w = b[7-i] ? m_one : m_zero;
            m_pulse(w, rr); m_pulse(w, rr);
        end
    endtask

    // Tick generation, counted-tick stamping and EAR edge checking
    int   tcount = 0;
    bit   pend = 0;
    logic prev_ear = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ear = ear; pend = 0; tick = 0; tcount = 0;
        end else begin
            tcount += int'(pend);
            if (ear !== prev_ear) begin
                if (idx >= n_exp) chk(0, "R11", idx, n_exp);
                else begin
                    chk((tcount == exp_t[idx]) && (ear == exp_l[idx]), exp_r[idx],
                        tcount, exp_t[idx]);
                    if (ear != exp_l[idx]) chk(0, exp_r[idx], int'(ear), int'(exp_l[idx]));
                end
                idx++;
                prev_ear = ear;
            end
            tick = run_ticks && ($urandom_range(99) < 55);
            pend = tick && busy;
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            nchecks++; nfail++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        int idle;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        tick  = 1'b0;
        // R12: first byte with reset widths (3 and 6)
        c_len_lo(1); c_len_hi(0);
        d_byte(8'hA5, "R12");
        // R5: data with zero count and an unknown opcode are dropped
        d_byte(8'h3C, "R5");
        put({1'b1, 8'h90});
        c_pulse(2, "R5");
        // R2 / R7: widths, then repeated pulse
        c_zero(4); c_one(7);
        c_rep(5); c_pulse(10, "R7");
        // R7: repeat consumed by a non-playing command
        c_rep(3); c_zero(4); c_pulse(2, "R7");
        // R10: zero width counts as one tick
        c_rep(0); c_pulse(0, "R10");
        // R8: gap after a high level, then repeated gap, zero gap
        c_gap(6, "R8");
        c_pulse(3, "R8");
        c_rep(2); c_gap(3, "R8");
        c_pulse(1, "R8");
        c_gap(0, "R10");
        c_pulse(2, "R10");
        // R6: pilot and sync sequence
        c_rep(20); c_pulse(12, "R6");
        c_pulse(3, "R6"); c_pulse(4, "R6");
        // R2 / R4: mid-block width change, partial final byte
        c_len_lo(2); c_len_hi(3 << 8);
        d_byte(8'hF0, "R3");
        c_zero(2);
        d_byte(8'hAB, "R2");
        // R9: flush drops remaining bytes and pending repeat
        c_len_lo(3); c_len_hi(0);
        d_byte(8'h81, "R3");
        c_flush();
        d_byte(8'hFF, "R9"); d_byte(8'h00, "R9");
        c_rep(4); c_flush(); c_pulse(5, "R9");
        // Random blocks
        for (int k = 0; k < 8; k++) begin
            int nbytes;
            c_zero($urandom_range(9, 0));
            c_one($urandom_range(12, 1));
            nbytes = $urandom_range(4, 1);
            c_len_lo(nbytes);
            c_len_hi($urandom_range(7, 0) << 8);
            for (int j = 0; j < nbytes; j++) begin
                d_byte(8'($urandom), "R3");
                if (j == 0 && (k % 3 == 0)) c_one($urandom_range(10, 1));
            end
            c_rep($urandom_range(4, 0));
            c_pulse($urandom_range(8, 1), "R7");
            if (k % 2 == 1) c_gap($urandom_range(5, 0), "R8");
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ear == 1'b0, "R12", int'(ear), 0);
        chk(busy == 1'b0, "R12", int'(busy), 0);
        chk(fifo_rd == 1'b0, "R1", int'(fifo_rd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_ticks = 1;

        idle = 0;
        while (idle < 12) begin
            @(negedge clk);
            if (rp == wp && !busy) idle++; else idle = 0;
        end
        chk(rp == wp, "R1", rp, wp);
        chk(idx == n_exp, "R11", idx, n_exp);
        chk(ear == m_e, "R8", int'(ear), int'(m_e));
        chk(busy == 1'b0, "R11", int'(busy), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end
endmodule